// File: doc/BRIEF.md
# Interruptible Block Fill Sequencer

This block runs a memory fill operation for one instruction. It stores the same data word over and over at ascending addresses. The element size comes from a 2-bit field. The number of elements left lives in a loop counter. A start pulse loads the operands: the data, the first address, the size code, the element count and the program counter of the instruction. The sequencer then issues single-beat writes one at a time on a request/acknowledge port. While it is active it raises a busy flag, and the memory pipeline must treat that flag as a block on every other memory operation.

The live counter and live address appear on output ports, so the architectural loop-count and address registers can be written back from them. Before each element the sequencer looks at the pending-interrupt input. If an interrupt is pending, it ends at once and reports completion with an interrupted flag, even though elements remain. The program counter it recorded at start stays visible as a resume address, so interrupt entry can return to the fill instruction. A fill that runs until its count reaches zero clears that recorded address to zero instead.

Top module: `strfill_engine`

## Requirements
- R1: After reset the block is idle: busy, write request, done and interrupted are 0, and the resume PC reads 0.
- R2: A start pulse in an idle cycle loads all operands, and busy reads 1 from the next cycle. A start pulse while busy is ignored: the count, address, data and resume PC are not disturbed.
- R3: At most one write is outstanding. While the request is high, its address equals the live address, its data equals the loaded data and its size equals the loaded size code, and all of them stay stable until the acknowledge.
- R4: In the cycle after an acknowledge, the live count drops by one and the live address rises by the element stride. The size code maps to the stride as 0 to 1 byte, 1 to 2 bytes, 2 to 4 bytes and 3 to 8 bytes.
- R5: Without an interrupt, done rises with interrupted at 0 only after the last acknowledge, and exactly the loaded number of writes is issued.
- R6: An interrupt is sampled only at an element boundary, which is a cycle with no request outstanding. If one is pending there and the count is non-zero, done and interrupted are 1 in that cycle and no further request is issued. A write already requested always completes first.
- R7: The resume PC takes the start PC when a start is accepted. It keeps that value after an interrupted finish and reads 0 after a normal finish.
- R8: A start with a count of zero raises done in the cycle after the start, issues no write, and clears the resume PC.
- R9: Busy stays 1 from the cycle after an accepted start through the cycle in which done is high, and reads 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a fill operation |
| start_data_i | input | DATA_W | Value to be stored |
| start_addr_i | input | ADDR_W | First byte address |
| start_size_i | input | 2 | Element size code (stride is 1 << code) |
| start_count_i | input | CNT_W | Number of elements to store |
| start_pc_i | input | PC_W | Program counter of the fill instruction |
| irq_pend_i | input | 1 | An interrupt is pending |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | DATA_W | Write data |
| wr_size_o | output | 2 | Write size code |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Operation active; blocks other memory operations |
| done_o | output | 1 | Completion, one cycle |
| done_irq_o | output | 1 | The completion was caused by an interrupt |
| cur_count_o | output | CNT_W | Live loop count |
| cur_addr_o | output | ADDR_W | Live address |
| resume_pc_o | output | PC_W | Recorded PC; 0 when no fill needs resuming |

## Verification
The bench sets the acknowledge latency at random and raises the interrupt at random. This places interrupts both at element boundaries and while a write is still waiting. A design that sampled the interrupt in mid-write would finish with its count and address out of step with the writes actually done. After an interrupted fill, the bench restarts it from the exposed count and address with the same PC. A lost or doubled element then shows up as a wrong address or write total. Directed cases cover a zero count, which must finish without writing, and the largest stride. They also cover a start pulse during a busy fill, which must leave all progress untouched, and a normal finish, which must clear the resume PC.

// File: rtl/strfill_pkg.sv
package strfill_pkg;
  typedef enum logic [1:0] {
    SF_IDLE = 2'd0,
    SF_EDGE = 2'd1,
    SF_WAIT = 2'd2
  } sf_state_e;

  localparam int unsigned SF_SIZE_W = 2;
endpackage

// File: rtl/strfill_ctrl.sv
module strfill_ctrl
  import strfill_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cnt_zero_i,
  input  logic irq_i,
  input  logic ack_i,
  output logic accept_o,
  output logic step_o,
  output logic req_o,
  output logic busy_o,
  output logic done_o,
  output logic intr_o,
  output logic norm_done_o
);
  sf_state_e state_q, state_d;
  logic boundary;

  always_comb begin
    boundary    = (state_q == SF_EDGE);
    accept_o    = (state_q == SF_IDLE) && start_i;
    req_o       = (state_q == SF_WAIT);
    step_o      = req_o && ack_i;
    done_o      = boundary && (cnt_zero_i || irq_i);
    intr_o      = boundary && !cnt_zero_i && irq_i;
    norm_done_o = boundary && cnt_zero_i;
    busy_o      = (state_q != SF_IDLE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SF_IDLE: if (accept_o) state_d = SF_EDGE;
      SF_EDGE: state_d = done_o ? SF_IDLE : SF_WAIT;
      SF_WAIT: if (ack_i) state_d = SF_EDGE;
      default: state_d = SF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SF_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/strfill_regs.sv
module strfill_regs #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] data_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        size_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              cnt_zero_o
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q, addr_d, stride;
  logic [1:0]        size_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ld_en, cnt_en;

  always_comb begin
    stride = ONE_A << size_q;
    ld_en  = accept_i;
    cnt_en = accept_i || step_i;
    addr_d = accept_i ? addr_i  : addr_q + stride;
    cnt_d  = accept_i ? count_i : cnt_q - ONE_C;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      size_q <= '0;
    end else if (ld_en) begin
      data_q <= data_i;
      size_q <= size_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign data_o     = data_q;
  assign addr_o     = addr_q;
  assign size_o     = size_q;
  assign count_o    = cnt_q;
  assign cnt_zero_o = (cnt_q == '0);
endmodule

// File: rtl/strfill_pcreg.sv
module strfill_pcreg #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            clear_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q, pc_d;
  logic            pc_en;

  always_comb begin
    pc_en = accept_i || clear_i;
    pc_d  = accept_i ? pc_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/strfill_engine.sv
module strfill_engine #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] start_data_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        start_size_i,
  input  logic [CNT_W-1:0]  start_count_i,
  input  logic [PC_W-1:0]   start_pc_i,
  input  logic              irq_pend_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [1:0]        wr_size_o,
  input  logic              wr_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_irq_o,
  output logic [CNT_W-1:0]  cur_count_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [PC_W-1:0]   resume_pc_o
);
  logic accept, step, cnt_zero, norm_done;
  logic [ADDR_W-1:0] addr;

  strfill_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnt_zero_i(cnt_zero),
    .irq_i(irq_pend_i), .ack_i(wr_ack_i), .accept_o(accept), .step_o(step),
    .req_o(wr_req_o), .busy_o(busy_o), .done_o(done_o), .intr_o(done_irq_o),
    .norm_done_o(norm_done)
  );

  strfill_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .step_i(step),
    .data_i(start_data_i), .addr_i(start_addr_i), .size_i(start_size_i),
    .count_i(start_count_i), .data_o(wr_data_o), .addr_o(addr),
    .size_o(wr_size_o), .count_o(cur_count_o), .cnt_zero_o(cnt_zero)
  );

  strfill_pcreg #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .clear_i(norm_done),
    .pc_i(start_pc_i), .pc_o(resume_pc_o)
  );

  assign wr_addr_o  = addr;
  assign cur_addr_o = addr;
endmodule

// File: rtl/strfill_engine_chk.sv
module strfill_engine_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PC_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              irq_pend_i,
  input logic              wr_req_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              done_irq_o,
  input logic [CNT_W-1:0]  cur_count_o
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && wr_ack_i |=> cur_count_o == $past(cur_count_o) - CNT_W'(1));
  // R5
  normal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !done_irq_o |-> cur_count_o == '0);
  // R6
  no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_req_o);
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq_o |-> irq_pend_i && done_o);
  // R9
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> busy_o);
endmodule

bind strfill_engine strfill_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PC_W(PC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .irq_pend_i(irq_pend_i),
  .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
  .wr_ack_i(wr_ack_i), .busy_o(busy_o), .done_o(done_o),
  .done_irq_o(done_irq_o), .cur_count_o(cur_count_o)
);

// File: tb/strfill_engine_tb.sv
module strfill_engine_tb_top;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PC_W   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [DATA_W-1:0] start_data_i = '0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [1:0] start_size_i = '0;
  logic [CNT_W-1:0] start_count_i = '0;
  logic [PC_W-1:0] start_pc_i = '0;
  logic irq_pend_i = 1'b0;
  logic wr_ack_i = 1'b0;
  logic wr_req_o, busy_o, done_o, done_irq_o;
  logic [ADDR_W-1:0] wr_addr_o, cur_addr_o;
  logic [DATA_W-1:0] wr_data_o;
  logic [1:0] wr_size_o;
  logic [CNT_W-1:0] cur_count_o;
  logic [PC_W-1:0] resume_pc_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  int unsigned cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strfill_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_data_i(start_data_i),
    .start_addr_i(start_addr_i), .start_size_i(start_size_i),
    .start_count_i(start_count_i), .start_pc_i(start_pc_i),
    .irq_pend_i(irq_pend_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_size_o(wr_size_o), .wr_ack_i(wr_ack_i),
    .busy_o(busy_o), .done_o(done_o), .done_irq_o(done_irq_o),
    .cur_count_o(cur_count_o), .cur_addr_o(cur_addr_o), .resume_pc_o(resume_pc_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] stride_of(input logic [1:0] sz);
    return ADDR_W'(1) << sz;
  endfunction

  // model state
  logic [CNT_W-1:0]  m_cnt;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_data;
  logic [1:0]        m_size;
  logic [PC_W-1:0]   m_pc;
  bit                last_intr;

  // Runs one operation; irq_pct is the interrupt chance per cycle, ack_pct the ack chance.
  task automatic run_op(input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] a,
                        input logic [1:0] sz, input logic [CNT_W-1:0] n,
                        input logic [PC_W-1:0] pc, input int irq_pct,
                        input int ack_pct, input bit poke_busy);
    int unsigned writes = 0;
    int unsigned iter = 0;
    logic [CNT_W-1:0] n0 = n;
    @(negedge clk);
    start_i = 1'b1; start_data_i = d; start_addr_i = a; start_size_i = sz;
    start_count_i = n; start_pc_i = pc;
    m_cnt = n; m_addr = a; m_data = d; m_size = sz; m_pc = pc;
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      iter++;
      if (poke_busy && iter == 2) begin
        start_i = 1'b1; start_count_i = 16'h7777; start_addr_i = 32'hDEAD0000;
        start_data_i = '1; start_pc_i = 32'h1234;
      end else start_i = 1'b0;
      irq_pend_i = ($urandom_range(99) < irq_pct);
      wr_ack_i   = wr_req_o && ($urandom_range(99) < ack_pct);
      #1;
      // R9
      check(busy_o === 1'b1, "R9 busy during op", busy_o, 1);
      check(cur_count_o === m_cnt, "R2/R4 live count", cur_count_o, m_cnt);
      check(cur_addr_o === m_addr, "R4 live address", cur_addr_o, m_addr);
      check(resume_pc_o === m_pc, "R7 pc held while running", resume_pc_o, m_pc);
      if (wr_req_o) begin
        check(wr_addr_o === m_addr && wr_data_o === m_data && wr_size_o === m_size,
              "R3 request fields", wr_addr_o, m_addr);
        check(done_o === 1'b0, "R6 no done with write pending", done_o, 0);
      end else begin
        check(done_o === (m_cnt == 0 || irq_pend_i), "R5/R6 boundary decision",
              done_o, (m_cnt == 0 || irq_pend_i));
        check(done_irq_o === (m_cnt != 0 && irq_pend_i), "R6 interrupted flag",
              done_irq_o, (m_cnt != 0 && irq_pend_i));
      end
      if (done_o) begin
        last_intr = done_irq_o;
        if (!done_irq_o) begin
          check(writes == n0, "R5 write total", writes, n0);
          if (n0 == 0) check(iter == 1, "R8 zero count finishes next cycle", iter, 1);
        end
        break;
      end
      if (wr_req_o && wr_ack_i) begin
        writes++;
        m_cnt  = m_cnt - 1'b1;
        m_addr = m_addr + stride_of(m_size);
      end
      @(negedge clk);
    end
    @(negedge clk);
    irq_pend_i = 1'b0; wr_ack_i = 1'b0; start_i = 1'b0;
    #1;
    check(busy_o === 1'b0, "R9 idle after done", busy_o, 0);
    check(resume_pc_o === (last_intr ? m_pc : '0), "R7 resume pc after finish",
          resume_pc_o, last_intr ? m_pc : '0);
    check(cur_count_o === m_cnt, "R6 count preserved", cur_count_o, m_cnt);
    check(cur_addr_o === m_addr, "R6 address preserved", cur_addr_o, m_addr);
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    #23;
    // R1
    check(busy_o === 1'b0 && wr_req_o === 1'b0 && done_o === 1'b0 && done_irq_o === 1'b0,
          "R1 reset outputs", {busy_o, wr_req_o, done_o, done_irq_o}, 0);
    check(resume_pc_o === '0, "R1 reset pc", resume_pc_o, 0);
    @(negedge clk); rst_n = 1'b1;
    // R8 zero count
    run_op(64'hA5A5, 32'h100, 2'd1, 16'd0, 32'h4000, 0, 100, 1'b0);
    // R4 largest stride, slow acks, no irq
    run_op(64'h1122334455667788, 32'h2000, 2'd3, 16'd5, 32'h4010, 0, 30, 1'b0);
    // R2 start while busy ignored
    run_op(64'h0F0F, 32'h3000, 2'd0, 16'd6, 32'h4020, 0, 50, 1'b1);
    // R6 interrupt certain at first boundary, then resume
    run_op(64'hBEEF, 32'h5000, 2'd2, 16'd4, 32'h4030, 100, 100, 1'b0);
    run_op(64'hBEEF, m_addr, 2'd2, m_cnt, 32'h4030, 0, 100, 1'b0);
    // random mix with resumption after interrupts
    for (int k = 0; k < 40; k++) begin
      logic [DATA_W-1:0] d = {$urandom, $urandom};
      logic [1:0] sz = 2'($urandom_range(3));
      logic [PC_W-1:0] pc = 32'h8000 + 32'(k * 4);
      run_op(d, $urandom & 32'hFFFF_FFF0, sz, 16'($urandom_range(12)), pc,
             $urandom_range(15), $urandom_range(20, 100), k % 7 == 3);
      while (last_intr)
        run_op(d, m_addr, sz, m_cnt, pc, $urandom_range(15), 70, 1'b0);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule